// File: doc/BRIEF.md
# Auto-Modify Address Register File

This block keeps a small set of 32-bit address registers and forms operand addresses from them. Seven registers serve general use. An eighth index reaches the stack pointer. There are two physical stack pointers, one for user code and one for supervisor code, and the privilege input picks which one index 7 means. Each address request names a register, an operand size and an addressing mode. The block returns the low 24 bits of the effective address and a flag for misaligned word or long accesses. When the mode asks for it, the block writes the stepped register value back in the same cycle that it accepts the request.

The address request is a stream with valid/ready handshakes on both sides. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its result appears on the next cycle, registered on the `res_*` outputs. While the consumer holds `res_ready` low, the result stays valid and unchanged and `req_ready` stays low. `req_ready` is high whenever no result is pending or the pending one is being taken in that cycle.

A separate plain port writes registers directly, either as a full 32-bit value or as a 16-bit value sign-extended to 32 bits. A combinational read port shows register contents. In supervisor mode, one extra index reaches the user stack pointer through both of these ports.

Top module: `addr_reg_unit`

## Requirements
- R1: After reset every register reads 0, `res_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and `res_valid` is 1 on the next cycle. While `res_valid` is 1 and `res_ready` is 0, `req_ready` is 0 and `res_addr`/`res_align_err` hold their values. `req_ready` = !`res_valid` or `res_ready`.
- R3: Mode code 0 (plain indirect) gives `res_addr` = low 24 bits of the selected register, and the register is left unchanged.
- R4: Mode code 1 (predecrement) lowers the register by the step, and `res_addr` is the lowered value.
- R5: Mode code 2 (postincrement) gives `res_addr` = the old register value and raises the register by the step.
- R6: Size code 0 is a byte with step 1, size code 1 is a word with step 2, and size codes 2 and 3 are long with step 4.
- R7: For register index 7 (the stack pointer), a byte-sized step is 2.
- R8: Mode code 3 (displacement) gives `res_addr` = register + the sign-extended 16-bit `req_disp`, and the register is left unchanged.
- R9: Index 7 selects the user stack pointer when `super_mode` = 0 and the supervisor stack pointer when `super_mode` = 1. This holds for requests, direct writes and reads.
- R10: A word or long request whose effective address is odd sets `res_align_err` = 1 and leaves the register unchanged. A byte request never sets it.
- R11: A direct write with `wr_long` = 1 stores all 32 bits of `wr_data`. With `wr_long` = 0 it stores `wr_data[15:0]` sign-extended from bit 15.
- R12: Direct-port index 8 reaches the user stack pointer only when `super_mode` = 1. Otherwise, and for indices above 8, writes are ignored and reads return 0.
- R13: When an accepted request updates the same physical register as a direct write in the same cycle, the request's update is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| super_mode | input | 1 | 1 = supervisor privilege, 0 = user |
| req_valid | input | 1 | Address request valid |
| req_ready | output | 1 | Block can take a request |
| req_reg | input | 3 | Register index (7 = stack pointer) |
| req_size | input | 2 | Operand size code |
| req_mode | input | 2 | Addressing mode code |
| req_disp | input | 16 | Signed displacement |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 24 | Effective bus address |
| res_align_err | output | 1 | Misaligned word/long access |
| wr_en | input | 1 | Direct register write enable |
| wr_idx | input | 4 | Direct write index (8 = user stack pointer in supervisor) |
| wr_long | input | 1 | 1 = 32-bit write, 0 = sign-extended 16-bit write |
| wr_data | input | 32 | Direct write data |
| rd_idx | input | 4 | Read index, same mapping as `wr_idx` |
| rd_data | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: seven general registers, 32-bit registers, a 24-bit address and a 16-bit displacement. This small shape lets the bench sweep every register index under both privilege levels, with every size and mode code and both even and odd starting values. Each case is computed arithmetically in the bench. The base values carry nonzero upper bytes so that the truncation to 24 bits is visible. Negative and positive displacements are both used. Directed cases cover back-pressure holding, stack-pointer aliasing across privilege changes, the privileged alias index, sign-extended writes and the write collision.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    AM_IND  = 2'd0,
    AM_PRE  = 2'd1,
    AM_POST = 2'd2,
    AM_DISP = 2'd3
  } amode_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } osize_t;
endpackage

// File: rtl/arf_step.sv
module arf_step
  import arf_pkg::*;
(
  input  osize_t     size,
  input  logic       on_sp,
  output logic [2:0] step
);
  always_comb begin
    unique case (size)
      SZ_BYTE: step = on_sp ? 3'd2 : 3'd1;
      SZ_WORD: step = 3'd2;
      default: step = 3'd4;
    endcase
  end
endmodule

// File: rtl/arf_agen.sv
module arf_agen
  import arf_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 16
) (
  input  logic [REG_W-1:0]  base,
  input  amode_t            mode,
  input  osize_t            size,
  input  logic              on_sp,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea,
  output logic [REG_W-1:0]  new_val,
  output logic              upd,
  output logic              err
);
  logic [2:0]        step;
  logic [ADDR_W-1:0] base_lo;
  logic [ADDR_W-1:0] step_a;
  logic [ADDR_W-1:0] disp_a;
  logic [REG_W-1:0]  step_r;

  arf_step u_step (.size(size), .on_sp(on_sp), .step(step));

  assign base_lo = base[ADDR_W-1:0];
  assign step_a  = ADDR_W'(step);
  assign step_r  = REG_W'(step);
  assign disp_a  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

  always_comb begin
    unique case (mode)
      AM_PRE:  ea = base_lo - step_a;
      AM_DISP: ea = base_lo + disp_a;
      default: ea = base_lo;
    endcase
    err     = (size != SZ_BYTE) && ea[0];
    upd     = ((mode == AM_PRE) || (mode == AM_POST)) && !err;
    new_val = (mode == AM_PRE) ? (base - step_r) : (base + step_r);
  end
endmodule

// File: rtl/arf_bank.sv
module arf_bank #(
  parameter int REG_W  = 32,
  parameter int NREG   = 9,
  parameter int PIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] a_idx,
  output logic [REG_W-1:0]  a_data,
  input  logic [PIDX_W-1:0] b_idx,
  output logic [REG_W-1:0]  b_data,
  input  logic              upd_en,
  input  logic [PIDX_W-1:0] upd_idx,
  input  logic [REG_W-1:0]  upd_data,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0]  wr_data
);
  logic [REG_W-1:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (upd_en && (upd_idx == PIDX_W'(r)))
        regs[r] <= upd_data;
      else if (wr_en && (wr_idx == PIDX_W'(r)))
        regs[r] <= wr_data;
    end
  end

  always_comb begin
    a_data = '0;
    b_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (a_idx == PIDX_W'(r)) a_data = regs[r];
      if (b_idx == PIDX_W'(r)) b_data = regs[r];
    end
  end
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
  import arf_pkg::*;
#(
  parameter int GP_REGS = 7,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 24,
  parameter int DISP_W  = 16,
  localparam int IDX_W  = $clog2(GP_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              super_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_reg,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_align_err,
  input  logic              wr_en,
  input  logic [IDX_W:0]    wr_idx,
  input  logic              wr_long,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W:0]    rd_idx,
  output logic [REG_W-1:0]  rd_data
);
  localparam int NPHYS  = GP_REGS + 2;
  localparam int PIDX_W = $clog2(NPHYS);
  localparam int USP_P  = GP_REGS;
  localparam int SSP_P  = GP_REGS + 1;
  localparam int HALF   = REG_W / 2;

  // Map a direct-port index to {valid, physical index}
  function automatic logic [PIDX_W:0] map_ext(input logic [IDX_W:0] idx, input logic sup);
    if (idx < (IDX_W+1)'(GP_REGS))
      return {1'b1, PIDX_W'(idx)};
    else if (idx == (IDX_W+1)'(GP_REGS))
      return {1'b1, sup ? PIDX_W'(SSP_P) : PIDX_W'(USP_P)};
    else if ((idx == (IDX_W+1)'(GP_REGS + 1)) && sup)
      return {1'b1, PIDX_W'(USP_P)};
    else
      return '0;
  endfunction

  logic              on_sp;
  logic [PIDX_W-1:0] req_phys;
  logic [REG_W-1:0]  req_base;
  logic [ADDR_W-1:0] ea;
  logic [REG_W-1:0]  new_val;
  logic              agen_upd, agen_err;
  logic              accept;
  logic [PIDX_W:0]   wmap, rmap;
  logic [REG_W-1:0]  wr_ext, rd_raw;

  assign on_sp    = (req_reg == IDX_W'(GP_REGS));
  assign req_phys = on_sp ? (super_mode ? PIDX_W'(SSP_P) : PIDX_W'(USP_P))
                          : PIDX_W'(req_reg);

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  assign wmap   = map_ext(wr_idx, super_mode);
  assign rmap   = map_ext(rd_idx, super_mode);
  assign wr_ext = wr_long ? wr_data : {{HALF{wr_data[HALF-1]}}, wr_data[HALF-1:0]};
  assign rd_data = rmap[PIDX_W] ? rd_raw : '0;

  arf_agen #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base    (req_base),
    .mode    (amode_t'(req_mode)),
    .size    (osize_t'(req_size)),
    .on_sp   (on_sp),
    .disp    (req_disp),
    .ea      (ea),
    .new_val (new_val),
    .upd     (agen_upd),
    .err     (agen_err)
  );

  arf_bank #(.REG_W(REG_W), .NREG(NPHYS), .PIDX_W(PIDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (req_phys),
    .a_data   (req_base),
    .b_idx    (rmap[PIDX_W-1:0]),
    .b_data   (rd_raw),
    .upd_en   (accept && agen_upd),
    .upd_idx  (req_phys),
    .upd_data (new_val),
    .wr_en    (wr_en && wmap[PIDX_W]),
    .wr_idx   (wmap[PIDX_W-1:0]),
    .wr_data  (wr_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_addr      <= '0;
      res_align_err <= 1'b0;
    end else if (accept) begin
      res_valid     <= 1'b1;
      res_addr      <= ea;
      res_align_err <= agen_err;
    end else if (res_ready) begin
      res_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/arf_checker.sv
module arf_checker #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mode,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_addr,
  input logic              res_align_err,
  input logic [REG_W-1:0]  base_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_align_err)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  p_err_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_align_err) |-> res_addr[0]);

  p_post_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 2'd2) |=> (res_addr == $past(base_q[ADDR_W-1:0])));

  p_ind_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 2'd0) |=> (res_addr == $past(base_q[ADDR_W-1:0])));
endmodule

bind addr_reg_unit arf_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_mode      (req_mode),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_addr      (res_addr),
  .res_align_err (res_align_err),
  .base_q        (req_base)
);

// File: tb/addr_reg_unit_test.sv
`timescale 1ns/1ps
module addr_reg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        super_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_reg = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_mode = '0;
  logic [15:0] req_disp = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [23:0] res_addr;
  logic        res_align_err;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic        wr_long = 1'b1;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [31:0] m [9];

  always #2.5 clk = ~clk;

  addr_reg_unit uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int phys(input int idx, input logic sup);
    if (idx < 7) return idx;
    if (idx == 7) return sup ? 8 : 7;
    if (idx == 8 && sup) return 7;
    return -1;
  endfunction

  task automatic set_reg(input int idx, input logic [31:0] val, input logic lng);
    int p;
    p = phys(idx, super_mode);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[3:0]; wr_data = val; wr_long = lng;
    @(negedge clk);
    wr_en = 1'b0;
    if (p >= 0) m[p] = lng ? val : {{16{val[15]}}, val[15:0]};
  endtask

  task automatic read_chk(input int idx, input logic [31:0] exp, input string tag);
    rd_idx = idx[3:0];
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic do_op(input int idx, input int sz, input int md, input logic [15:0] dsp,
                       input string tag);
    int p, st;
    logic [31:0] b, ea, nv;
    logic er;
    p  = phys(idx, super_mode);
    b  = m[p];
    st = (sz == 0) ? ((idx == 7) ? 2 : 1) : ((sz == 1) ? 2 : 4);
    case (md)
      1: ea = b - st;
      3: ea = b + {{16{dsp[15]}}, dsp};
      default: ea = b;
    endcase
    er = (sz != 0) && ea[0];
    nv = b;
    if (!er && md == 1) nv = b - st;
    if (!er && md == 2) nv = b + st;
    m[p] = nv;
    @(negedge clk);
    req_valid = 1'b1; req_reg = idx[2:0]; req_size = sz[1:0]; req_mode = md[1:0]; req_disp = dsp;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 valid"}, {31'b0, res_valid}, 32'd1);
    chk({tag, " addr"}, {8'h0, res_addr}, {8'h0, ea[23:0]});
    chk({tag, " R10 err"}, {31'b0, res_align_err}, {31'b0, er});
    read_chk(idx, nv, {tag, " reg"});
  endtask

  initial begin
    string mt [4];
    mt[0] = "R3 ind"; mt[1] = "R4 pre"; mt[2] = "R5 post"; mt[3] = "R8 disp";
    for (int i = 0; i < 9; i++) m[i] = '0;

    // R1 reset state
    #1;
    chk("R1 res_valid in reset", {31'b0, res_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    for (int i = 0; i < 8; i++) read_chk(i, 32'd0, "R1 reg zero");

    // Sweep: privilege, register, size, mode, odd/even base (R3-R10, R6, R7, R9)
    for (int s = 0; s < 2; s++) begin
      super_mode = s[0];
      for (int idx = 0; idx < 8; idx++)
        for (int sz = 0; sz < 4; sz++)
          for (int md = 0; md < 4; md++)
            for (int od = 0; od < 2; od++) begin
              logic [31:0] base;
              logic [15:0] dsp;
              base = 32'hC3A0_1000 + 32'(idx << 4) + 32'(od);
              dsp  = od ? 16'h0007 : 16'hFFF2;
              set_reg(idx, base, 1'b1);
              do_op(idx, sz, md, dsp,
                    $sformatf("%s R6 sz%0d %s idx%0d sup%0d od%0d", mt[md], sz,
                              (idx == 7) ? "R7 R9 sp" : "gp", idx, s, od));
            end
    end

    // R9 stack pointer aliasing across privilege
    super_mode = 1'b1;
    set_reg(7, 32'h0000_1000, 1'b1);
    set_reg(8, 32'h0000_2000, 1'b1);
    read_chk(7, 32'h0000_1000, "R9 ssp in super");
    read_chk(8, 32'h0000_2000, "R12 usp alias in super");
    super_mode = 1'b0;
    read_chk(7, 32'h0000_2000, "R9 usp in user");
    do_op(7, 1, 2, 16'h0, "R9 R5 user sp post");
    super_mode = 1'b1;
    read_chk(8, 32'h0000_2002, "R9 usp after user op");
    read_chk(7, 32'h0000_1000, "R9 ssp untouched");

    // R12 alias ignored in user mode, out-of-range index ignored
    super_mode = 1'b0;
    set_reg(8, 32'hDEAD_BEEF, 1'b1);
    read_chk(8, 32'd0, "R12 alias reads 0 in user");
    set_reg(9, 32'h1234_5678, 1'b1);
    read_chk(9, 32'd0, "R12 idx9 reads 0");
    super_mode = 1'b1;
    read_chk(8, 32'h0000_2002, "R12 usp kept after user write");
    read_chk(7, 32'h0000_1000, "R12 ssp kept");
    for (int i = 0; i < 7; i++) read_chk(i, m[i], "R12 gp kept");
    super_mode = 1'b0;

    // R11 sign extension
    set_reg(3, 32'h0000_8001, 1'b0);
    read_chk(3, 32'hFFFF_8001, "R11 neg sext");
    set_reg(3, 32'h1234_7FFF, 1'b0);
    read_chk(3, 32'h0000_7FFF, "R11 pos sext");
    set_reg(3, 32'h8765_4321, 1'b1);
    read_chk(3, 32'h8765_4321, "R11 long");

    // R2 back-pressure
    set_reg(0, 32'h0000_0040, 1'b1);
    set_reg(1, 32'h0000_0080, 1'b1);
    res_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_reg = 3'd0; req_size = 2'd1; req_mode = 2'd0; req_disp = '0;
    @(negedge clk);
    chk("R2 first valid", {31'b0, res_valid}, 32'd1);
    chk("R2 first addr", {8'h0, res_addr}, 32'h40);
    chk("R2 ready low", {31'b0, req_ready}, 32'd0);
    req_reg = 3'd1; req_size = 2'd2; req_mode = 2'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 held valid", {31'b0, res_valid}, 32'd1);
      chk("R2 held addr", {8'h0, res_addr}, 32'h40);
      read_chk(1, 32'h0000_0080, "R2 stalled req no update");
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second valid", {31'b0, res_valid}, 32'd1);
    chk("R2 second addr", {8'h0, res_addr}, 32'h80);
    read_chk(1, 32'h0000_0084, "R2 second update");
    m[1] = 32'h84;
    @(negedge clk);
    chk("R2 drained", {31'b0, res_valid}, 32'd0);

    // R13 collision: request update wins
    set_reg(2, 32'h0000_0100, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_reg = 3'd2; req_size = 2'd2; req_mode = 2'd2;
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h5555_5555; wr_long = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R13 addr", {8'h0, res_addr}, 32'h100);
    read_chk(2, 32'h0000_0104, "R13 request wins");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule